// File: doc/BRIEF.md
# GPU Pushbuffer Method Stream Decoder

This block turns a flat stream of 32-bit command-buffer words into a sequence of method calls. Each word is either a command header or a data word for the command that is open at that moment. A header selects how the method address moves over the data words that follow it. Each data word then produces one call, which carries the method address, the 32-bit argument, the subchannel and the number of calls still owed. An inline header produces its single call by itself, with its immediate field as the argument. A long-form header takes its call count from the next word in the stream.

Words arrive under a valid/ready handshake, at most one per cycle. Before any word is accepted, a segment-start strobe loads a word budget. Words are accepted only while that budget is non-zero. Decoder state carries across segment boundaries, so one command can span several segments. Calls leave through a registered output, and the input is stalled while a call waits for the downstream consumer.

Top module: `pbuf_method_decoder`

## Requirements
- R1: A word taken while no command is open, and no count is pending, is a header. Its fields are: mode in bits [31:29], count or immediate in [28:16], subchannel in [15:13] and method address in [12:0]. The mode codes are 001 stepping, 011 fixed-address, 101 step-once, 100 inline and 000 long-form.
- R2: In stepping mode, data word k (counting from 0) calls method address header address + k.
- R3: In fixed-address mode, every data word calls the header's method address.
- R4: In step-once mode, the first data word calls the header address. Every later data word calls the header address + 1.
- R5: An inline header issues one call by itself. The argument is the zero-extended 13-bit immediate, the remaining count is 0, and the next word is again a header.
- R6: Each data word issues one call whose remaining field equals the open count before that word, and the count then drops by one. A header with count 0 issues no call, and the word after it is a header.
- R7: A long-form header issues no call. The next word supplies the call count in its bits [15:0] and is not a call. The data words that follow use fixed-address mode at the header's method address and subchannel.
- R8: A header with mode 010, 110 or 111 issues no call and changes no state. The next word is decoded as a header.
- R9: A segment-start strobe loads its length as the word budget, but only when the budget is zero; otherwise the strobe is ignored. A length of zero leaves both the budget and the decoder state unchanged. in_ready is low whenever the budget is zero, and each accepted word uses one unit of budget.
- R10: A call appears on out_valid in the cycle after its word is accepted. It stays with stable fields until out_ready is high. While a call is held, in_ready is low.
- R11: A synchronous reset clears the budget, the open count, the pending-length flag and the output. The first word of the next segment is therefore decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_start | input | 1 | Segment start strobe |
| seg_len | input | 16 | Word count of the starting segment |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted when high together with in_valid |
| out_valid | output | 1 | Method call valid |
| out_ready | input | 1 | Consumer takes the call |
| out_method | output | 13 | Method address of the call |
| out_arg | output | 32 | Call argument |
| out_subch | output | 3 | Subchannel of the call |
| out_remain | output | 16 | Calls still owed by the command, including this one (0 for inline) |

## Verification
The hardest states to reach are those where a command is split by the segment structure or by back-pressure. Examples are a long-form count word arriving in a later segment than its header, a zero-length segment falling between a header and its data, and a step-once command whose second call is stalled at the output. A generator builds a legal command stream that mixes every mode, including unrecognised ones. It cuts that stream at random points into segments, some of them empty, while out_ready drops at random. A behavioural model in the bench is compared against the ports on every cycle during this run. Directed sequences then pin each mode, a stall held for several cycles, an ignored strobe and a reset in the middle of a command.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] HM_LONG   = 3'b000;
   localparam logic [MODE_W-1:0] HM_STEP   = 3'b001;
   localparam logic [MODE_W-1:0] HM_HOLD   = 3'b011;
   localparam logic [MODE_W-1:0] HM_INLINE = 3'b100;
   localparam logic [MODE_W-1:0] HM_ONCE   = 3'b101;

   typedef enum logic [1:0] {
      HK_NONE,
      HK_BURST,
      HK_INLINE,
      HK_LONG
   } hdr_kind_e;

   typedef enum logic [1:0] {
      AM_STEP,
      AM_HOLD,
      AM_ONCE
   } addr_mode_e;

endpackage

// File: rtl/pmd_seg_budget.sv
module pmd_seg_budget #(
   parameter int SEG_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             seg_start,
   input  logic [SEG_W-1:0] seg_len,
   input  logic             take,
   output logic             has_words
);

   logic [SEG_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q <= '0;
      end else if (seg_start && (left_q == '0)) begin
         left_q <= seg_len;
      end else if (take) begin
         left_q <= left_q - SEG_W'(1);
      end
   end

   assign has_words = (left_q != '0);

endmodule

// File: rtl/pmd_hdr_decode.sv
module pmd_hdr_decode
   import pmd_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int METHOD_W = 13,
   parameter int SUBCH_W  = 3,
   parameter int CNT_W    = 13,
   parameter int LCNT_W   = 16
) (
   input  logic [DATA_W-1:0]   word,
   output hdr_kind_e           d_kind,
   output addr_mode_e          d_amode,
   output logic [METHOD_W-1:0] d_meth,
   output logic [SUBCH_W-1:0]  d_sub,
   output logic [LCNT_W-1:0]   d_count,
   output logic [DATA_W-1:0]   d_imm
);

   localparam int SUB_LO  = METHOD_W;
   localparam int CNT_LO  = METHOD_W + SUBCH_W;
   localparam int MODE_LO = CNT_LO + CNT_W;

   logic [MODE_W-1:0] mode;
   logic [CNT_W-1:0]  field;

   assign mode   = word[MODE_LO +: MODE_W];
   assign field  = word[CNT_LO +: CNT_W];
   assign d_meth = word[0 +: METHOD_W];
   assign d_sub  = word[SUB_LO +: SUBCH_W];

   generate
      if (LCNT_W == CNT_W) begin : g_cnt_same
         assign d_count = field;
      end else begin : g_cnt_pad
         assign d_count = {{(LCNT_W-CNT_W){1'b0}}, field};
      end
      if (DATA_W == CNT_W) begin : g_imm_same
         assign d_imm = field;
      end else begin : g_imm_pad
         assign d_imm = {{(DATA_W-CNT_W){1'b0}}, field};
      end
   endgenerate

   always_comb begin
      d_kind  = HK_NONE;
      d_amode = AM_HOLD;
      unique case (mode)
         HM_STEP:   begin d_kind = HK_BURST;  d_amode = AM_STEP; end
         HM_HOLD:   begin d_kind = HK_BURST;  d_amode = AM_HOLD; end
         HM_ONCE:   begin d_kind = HK_BURST;  d_amode = AM_ONCE; end
         HM_INLINE: begin d_kind = HK_INLINE; d_amode = AM_HOLD; end
         HM_LONG:   begin d_kind = HK_LONG;   d_amode = AM_HOLD; end
         default:   begin d_kind = HK_NONE;   d_amode = AM_HOLD; end
      endcase
   end

endmodule

// File: rtl/pmd_exec.sv
module pmd_exec
   import pmd_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int METHOD_W = 13,
   parameter int SUBCH_W  = 3,
   parameter int LCNT_W   = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                fire,
   input  logic [DATA_W-1:0]   word,
   input  hdr_kind_e           d_kind,
   input  addr_mode_e          d_amode,
   input  logic [METHOD_W-1:0] d_meth,
   input  logic [SUBCH_W-1:0]  d_sub,
   input  logic [LCNT_W-1:0]   d_count,
   input  logic [DATA_W-1:0]   d_imm,
   input  logic                out_ready,
   output logic                out_valid,
   output logic [METHOD_W-1:0] out_method,
   output logic [DATA_W-1:0]   out_arg,
   output logic [SUBCH_W-1:0]  out_subch,
   output logic [LCNT_W-1:0]   out_remain,
   output logic [LCNT_W-1:0]   st_cnt,
   output logic                st_len_pend
);

   logic [METHOD_W-1:0] cur_meth;
   logic [SUBCH_W-1:0]  cur_sub;
   addr_mode_e          amode;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_cnt      <= '0;
         st_len_pend <= 1'b0;
         amode       <= AM_STEP;
         cur_meth    <= '0;
         cur_sub     <= '0;
         out_valid   <= 1'b0;
         out_method  <= '0;
         out_arg     <= '0;
         out_subch   <= '0;
         out_remain  <= '0;
      end else begin
         if (out_valid && out_ready) begin
            out_valid <= 1'b0;
         end
         if (fire) begin
            if (st_len_pend) begin
               st_len_pend <= 1'b0;
               st_cnt      <= word[LCNT_W-1:0];
            end else if (st_cnt != '0) begin
               out_valid  <= 1'b1;
               out_method <= cur_meth;
               out_arg    <= word;
               out_subch  <= cur_sub;
               out_remain <= st_cnt;
               st_cnt     <= st_cnt - LCNT_W'(1);
               if (amode == AM_STEP) begin
                  cur_meth <= cur_meth + METHOD_W'(1);
               end else if (amode == AM_ONCE) begin
                  cur_meth <= cur_meth + METHOD_W'(1);
                  amode    <= AM_HOLD;
               end
            end else begin
               unique case (d_kind)
                  HK_BURST: begin
                     cur_meth <= d_meth;
                     cur_sub  <= d_sub;
                     st_cnt   <= d_count;
                     amode    <= d_amode;
                  end
                  HK_INLINE: begin
                     out_valid  <= 1'b1;
                     out_method <= d_meth;
                     out_arg    <= d_imm;
                     out_subch  <= d_sub;
                     out_remain <= '0;
                     cur_meth   <= d_meth;
                     cur_sub    <= d_sub;
                     amode      <= AM_HOLD;
                  end
                  HK_LONG: begin
                     cur_meth    <= d_meth;
                     cur_sub     <= d_sub;
                     amode       <= AM_HOLD;
                     st_len_pend <= 1'b1;
                  end
                  default: begin
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/pbuf_method_decoder.sv
module pbuf_method_decoder
   import pmd_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int METHOD_W = 13,
   parameter int SUBCH_W  = 3,
   parameter int CNT_W    = 13,
   parameter int LCNT_W   = 16,
   parameter int SEG_W    = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                seg_start,
   input  logic [SEG_W-1:0]    seg_len,
   input  logic                in_valid,
   input  logic [DATA_W-1:0]   in_data,
   output logic                in_ready,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [METHOD_W-1:0] out_method,
   output logic [DATA_W-1:0]   out_arg,
   output logic [SUBCH_W-1:0]  out_subch,
   output logic [LCNT_W-1:0]   out_remain
);

   localparam int HDR_BITS = MODE_W + CNT_W + SUBCH_W + METHOD_W;

   generate
      if (HDR_BITS != DATA_W) begin : g_bad_layout
         $error("header fields must fill the command word exactly");
      end
      if (LCNT_W < CNT_W || LCNT_W > DATA_W) begin : g_bad_lcnt
         $error("long count width must lie between header count and word width");
      end
      if (SEG_W < 1) begin : g_bad_seg
         $error("segment length width must be positive");
      end
   endgenerate

   logic                seg_has_words;
   logic                fire;
   hdr_kind_e           d_kind;
   addr_mode_e          d_amode;
   logic [METHOD_W-1:0] d_meth;
   logic [SUBCH_W-1:0]  d_sub;
   logic [LCNT_W-1:0]   d_count;
   logic [DATA_W-1:0]   d_imm;
   logic [LCNT_W-1:0]   st_cnt;
   logic                st_len_pend;

   assign in_ready = seg_has_words && (!out_valid || out_ready);
   assign fire     = in_valid && in_ready;

   pmd_seg_budget #(
      .SEG_W (SEG_W)
   ) budget_i (
      .clk       (clk),
      .rst       (rst),
      .seg_start (seg_start),
      .seg_len   (seg_len),
      .take      (fire),
      .has_words (seg_has_words)
   );

   pmd_hdr_decode #(
      .DATA_W   (DATA_W),
      .METHOD_W (METHOD_W),
      .SUBCH_W  (SUBCH_W),
      .CNT_W    (CNT_W),
      .LCNT_W   (LCNT_W)
   ) dec_i (
      .word    (in_data),
      .d_kind  (d_kind),
      .d_amode (d_amode),
      .d_meth  (d_meth),
      .d_sub   (d_sub),
      .d_count (d_count),
      .d_imm   (d_imm)
   );

   pmd_exec #(
      .DATA_W   (DATA_W),
      .METHOD_W (METHOD_W),
      .SUBCH_W  (SUBCH_W),
      .LCNT_W   (LCNT_W)
   ) exec_i (
      .clk         (clk),
      .rst         (rst),
      .fire        (fire),
      .word        (in_data),
      .d_kind      (d_kind),
      .d_amode     (d_amode),
      .d_meth      (d_meth),
      .d_sub       (d_sub),
      .d_count     (d_count),
      .d_imm       (d_imm),
      .out_ready   (out_ready),
      .out_valid   (out_valid),
      .out_method  (out_method),
      .out_arg     (out_arg),
      .out_subch   (out_subch),
      .out_remain  (out_remain),
      .st_cnt      (st_cnt),
      .st_len_pend (st_len_pend)
   );

endmodule

// File: rtl/pbuf_method_decoder_chk.sv
module pbuf_method_decoder_chk
   import pmd_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int METHOD_W = 13,
   parameter int SUBCH_W  = 3,
   parameter int CNT_W    = 13,
   parameter int LCNT_W   = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [DATA_W-1:0]   in_data,
   input logic                in_ready,
   input logic                out_valid,
   input logic                out_ready,
   input logic [METHOD_W-1:0] out_method,
   input logic [DATA_W-1:0]   out_arg,
   input logic [SUBCH_W-1:0]  out_subch,
   input logic [LCNT_W-1:0]   out_remain,
   input logic [LCNT_W-1:0]   st_cnt,
   input logic                st_len_pend,
   input logic                seg_has_words
);

   localparam int CNT_LO  = METHOD_W + SUBCH_W;
   localparam int MODE_LO = CNT_LO + CNT_W;

   logic              fire;
   logic              hdr_slot;
   logic [MODE_W-1:0] mode;
   logic              unk_mode;

   assign fire     = in_valid && in_ready;
   assign hdr_slot = (st_cnt == '0) && !st_len_pend;
   assign mode     = in_data[MODE_LO +: MODE_W];
   assign unk_mode = (mode != HM_LONG) && (mode != HM_STEP) && (mode != HM_HOLD) &&
                     (mode != HM_INLINE) && (mode != HM_ONCE);

   // R10: a call that is not taken stays put
   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_method) && $stable(out_arg) &&
                                  $stable(out_subch) && $stable(out_remain));

   // R10: input stalled while a call waits
   p_stall_r10: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);

   // R9: no word accepted without budget
   p_budget_r9: assert property (@(posedge clk) disable iff (rst)
      !seg_has_words |-> !in_ready);

   // R5: inline header becomes a call with its immediate
   p_inline_r5: assert property (@(posedge clk) disable iff (rst)
      fire && hdr_slot && (mode == HM_INLINE) |=>
         out_valid && (out_remain == '0) && (st_cnt == '0) &&
         (out_arg == DATA_W'($past(in_data[CNT_LO +: CNT_W]))));

   // R6: data word makes a call and counts down
   p_data_r6: assert property (@(posedge clk) disable iff (rst)
      fire && (st_cnt != '0) && !st_len_pend |=>
         out_valid && (out_remain == $past(st_cnt)) &&
         (st_cnt == $past(st_cnt) - LCNT_W'(1)) && (out_arg == $past(in_data)));

   // R7: word after a long-form header is the count
   p_len_r7: assert property (@(posedge clk) disable iff (rst)
      fire && st_len_pend |=>
         !st_len_pend && (st_cnt == $past(in_data[LCNT_W-1:0])) &&
         (out_valid == ($past(out_valid) && !$past(out_ready))));

   // R8: unrecognised header changes nothing and calls nothing
   p_unknown_r8: assert property (@(posedge clk) disable iff (rst)
      fire && hdr_slot && unk_mode |=>
         (st_cnt == '0) && !st_len_pend &&
         (out_valid == ($past(out_valid) && !$past(out_ready))));

   // R11: state is clear when reset ends
   p_reset_r11: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (st_cnt == '0) && !st_len_pend && !out_valid && !seg_has_words);

endmodule

bind pbuf_method_decoder pbuf_method_decoder_chk #(
   .DATA_W   (DATA_W),
   .METHOD_W (METHOD_W),
   .SUBCH_W  (SUBCH_W),
   .CNT_W    (CNT_W),
   .LCNT_W   (LCNT_W)
) chk_i (
   .clk           (clk),
   .rst           (rst),
   .in_valid      (in_valid),
   .in_data       (in_data),
   .in_ready      (in_ready),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_method    (out_method),
   .out_arg       (out_arg),
   .out_subch     (out_subch),
   .out_remain    (out_remain),
   .st_cnt        (st_cnt),
   .st_len_pend   (st_len_pend),
   .seg_has_words (seg_has_words)
);

// File: tb/pbuf_method_decoder_tb_top.sv
module pbuf_method_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        seg_start = 1'b0;
   logic [15:0] seg_len = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [12:0] out_method;
   logic [31:0] out_arg;
   logic [2:0]  out_subch;
   logic [15:0] out_remain;

   always #5 clk = ~clk;

   pbuf_method_decoder dut_i (
      .clk        (clk),
      .rst        (rst),
      .seg_start  (seg_start),
      .seg_len    (seg_len),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_ready   (in_ready),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_method (out_method),
      .out_arg    (out_arg),
      .out_subch  (out_subch),
      .out_remain (out_remain)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req  = "R1";
   bit    stall_mode = 1'b0;
   int    cyc = 0;

   task automatic check(input bit ok, input string req, input string msg);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s", req, msg);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_budget;
   logic [15:0] m_cnt;
   bit          m_lp;
   int          m_am;     // 0 step, 1 hold, 2 step-once
   logic [12:0] m_meth;
   logic [2:0]  m_sub;
   bit          m_ov;
   logic [12:0] e_meth;
   logic [31:0] e_arg;
   logic [2:0]  e_sub;
   logic [15:0] e_rem;
   bit          m_fire;

   task automatic model_word(input logic [31:0] w);
      if (m_lp) begin
         m_lp  = 1'b0;
         m_cnt = w[15:0];
      end else if (m_cnt != 0) begin
         m_ov = 1'b1; e_meth = m_meth; e_arg = w; e_sub = m_sub; e_rem = m_cnt;
         m_cnt = m_cnt - 16'd1;
         if (m_am == 0) m_meth = m_meth + 13'd1;
         else if (m_am == 2) begin m_meth = m_meth + 13'd1; m_am = 1; end
      end else begin
         case (w[31:29])
            3'b001, 3'b011, 3'b101: begin
               m_meth = w[12:0]; m_sub = w[15:13]; m_cnt = {3'b000, w[28:16]};
               m_am = (w[31:29] == 3'b001) ? 0 : (w[31:29] == 3'b011) ? 1 : 2;
            end
            3'b100: begin
               m_ov = 1'b1; e_meth = w[12:0]; e_arg = {19'd0, w[28:16]};
               e_sub = w[15:13]; e_rem = 16'd0;
               m_meth = w[12:0]; m_sub = w[15:13]; m_am = 1;
            end
            3'b000: begin
               m_meth = w[12:0]; m_sub = w[15:13]; m_am = 1; m_lp = 1'b1;
            end
            default: ;
         endcase
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_budget = 0; m_cnt = '0; m_lp = 1'b0; m_am = 0; m_meth = '0; m_sub = '0;
         m_ov = 1'b0; e_meth = '0; e_arg = '0; e_sub = '0; e_rem = '0;
      end else begin
         m_fire = in_valid && (m_budget != 0) && (!m_ov || out_ready);
         if (m_ov && out_ready) m_ov = 1'b0;
         if (seg_start && (m_budget == 0)) begin
            m_budget = int'(seg_len);
         end else if (m_fire) begin
            m_budget--;
            model_word(in_data);
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst) begin
         bit exp_ready;
         exp_ready = (m_budget != 0) && (!m_ov || out_ready);
         check(in_ready === exp_ready, cur_req,
               $sformatf("in_ready got %b exp %b", in_ready, exp_ready));
         check(out_valid === m_ov, cur_req,
               $sformatf("out_valid got %b exp %b", out_valid, m_ov));
         if (m_ov) begin
            check(out_method === e_meth && out_arg === e_arg &&
                  out_subch === e_sub && out_remain === e_rem, cur_req,
                  $sformatf("call got %h/%h/%h/%h exp %h/%h/%h/%h",
                            out_method, out_arg, out_subch, out_remain,
                            e_meth, e_arg, e_sub, e_rem));
         end
      end
   end

   // ---------------- call capture for directed checks ----------------
   typedef struct packed {
      logic [12:0] m;
      logic [31:0] a;
      logic [2:0]  s;
      logic [15:0] r;
   } call_t;
   call_t got[$];

   always @(posedge clk) begin
      if (!rst && out_valid && out_ready) begin
         got.push_back('{m: out_method, a: out_arg, s: out_subch, r: out_remain});
      end
   end

   task automatic expect_call(input int idx, input logic [12:0] m, input logic [31:0] a,
                              input logic [2:0] s, input logic [15:0] r, input string req);
      if (idx >= got.size()) begin
         check(1'b0, req, $sformatf("call %0d missing got size %0d exp > %0d",
                                    idx, got.size(), idx));
      end else begin
         check(got[idx].m === m && got[idx].a === a && got[idx].s === s && got[idx].r === r,
               req, $sformatf("call %0d got %h/%h/%h/%h exp %h/%h/%h/%h", idx,
                              got[idx].m, got[idx].a, got[idx].s, got[idx].r, m, a, s, r));
      end
   endtask

   task automatic expect_count(input int n, input string req);
      check(got.size() == n, req, $sformatf("call count got %0d exp %0d", got.size(), n));
   endtask

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] hdr(input int mode, input int cnt, input int sub, input int meth);
      logic [2:0]  md = mode[2:0];
      logic [12:0] ct = cnt[12:0];
      logic [2:0]  sb = sub[2:0];
      logic [12:0] mt = meth[12:0];
      return {md, ct, sb, mt};
   endfunction

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic seg(input int len);
      in_valid  = 1'b0;
      seg_start = 1'b1;
      seg_len   = len[15:0];
      out_ready = 1'b1;
      tick();
      seg_start = 1'b0;
   endtask

   task automatic send(input logic [31:0] w);
      bit acc;
      acc = 1'b0;
      in_valid = 1'b1;
      in_data  = w;
      while (!acc) begin
         out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
         #3;
         acc = in_ready;
         tick();
      end
      in_valid = 1'b0;
   endtask

   task automatic drain();
      in_valid  = 1'b0;
      out_ready = 1'b1;
      repeat (3) tick();
   endtask

   task automatic send_seg(input logic [31:0] ws[$]);
      seg(ws.size());
      foreach (ws[i]) send(ws[i]);
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired actual %0d cycles expected under 150000", cyc);
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   // ---------------- tests ----------------
   initial begin
      logic [31:0] ws[$];
      int          exp_calls;

      repeat (3) @(negedge clk);
      cur_req = "R11";
      check(in_ready === 1'b0 && out_valid === 1'b0, "R11",
            $sformatf("reset outputs got %b/%b exp 0/0", in_ready, out_valid));
      #1 rst = 1'b0;
      tick();
      check(in_ready === 1'b0, "R9", $sformatf("no budget in_ready got %b exp 0", in_ready));

      // R2 stepping mode, R1 header layout
      cur_req = "R2"; got.delete();
      send_seg('{hdr(1, 3, 2, 'h100), 32'hA0, 32'hA1, 32'hA2});
      drain();
      expect_count(3, "R2");
      expect_call(0, 13'h100, 32'hA0, 3'd2, 16'd3, "R1");
      expect_call(1, 13'h101, 32'hA1, 3'd2, 16'd2, "R2");
      expect_call(2, 13'h102, 32'hA2, 3'd2, 16'd1, "R2");

      // R3 fixed address
      cur_req = "R3"; got.delete();
      send_seg('{hdr(3, 2, 5, 'h40), 32'hB0, 32'hB1});
      drain();
      expect_count(2, "R3");
      expect_call(0, 13'h40, 32'hB0, 3'd5, 16'd2, "R3");
      expect_call(1, 13'h40, 32'hB1, 3'd5, 16'd1, "R3");

      // R4 step once
      cur_req = "R4"; got.delete();
      send_seg('{hdr(5, 3, 1, 'h200), 32'hC0, 32'hC1, 32'hC2});
      drain();
      expect_count(3, "R4");
      expect_call(0, 13'h200, 32'hC0, 3'd1, 16'd3, "R4");
      expect_call(1, 13'h201, 32'hC1, 3'd1, 16'd2, "R4");
      expect_call(2, 13'h201, 32'hC2, 3'd1, 16'd1, "R4");

      // R5 inline, next word is a header again
      cur_req = "R5"; got.delete();
      send_seg('{hdr(4, 'h1ABC, 1, 'h55), hdr(1, 1, 0, 'h7), 32'hD0});
      drain();
      expect_count(2, "R5");
      expect_call(0, 13'h55, 32'h0000_1ABC, 3'd1, 16'd0, "R5");
      expect_call(1, 13'h7, 32'hD0, 3'd0, 16'd1, "R5");

      // R7 long form
      cur_req = "R7"; got.delete();
      send_seg('{hdr(0, 0, 4, 'h30), 32'hFFFF_0002, 32'hE0, 32'hE1});
      drain();
      expect_count(2, "R7");
      expect_call(0, 13'h30, 32'hE0, 3'd4, 16'd2, "R7");
      expect_call(1, 13'h30, 32'hE1, 3'd4, 16'd1, "R7");

      // R8 unrecognised modes
      cur_req = "R8"; got.delete();
      send_seg('{hdr(2, 5, 3, 'h99), hdr(6, 1, 1, 'h1), hdr(7, 2, 2, 'h2),
                 hdr(1, 1, 6, 'h9), 32'hF0});
      drain();
      expect_count(1, "R8");
      expect_call(0, 13'h9, 32'hF0, 3'd6, 16'd1, "R8");

      // R6 zero-count header
      cur_req = "R6"; got.delete();
      send_seg('{hdr(1, 0, 0, 'h10), hdr(1, 1, 3, 'h11), 32'h1234});
      drain();
      expect_count(1, "R6");
      expect_call(0, 13'h11, 32'h1234, 3'd3, 16'd1, "R6");

      // R9 zero-length segment and ignored strobe
      cur_req = "R9"; got.delete();
      seg(0);
      tick();
      check(in_ready === 1'b0, "R9", $sformatf("zero segment in_ready got %b exp 0", in_ready));
      seg(3);
      send(hdr(1, 2, 0, 'h70));
      seg(10);
      send(32'h51);
      seg(0);
      send(32'h52);
      drain();
      check(in_ready === 1'b0, "R9",
            $sformatf("budget after ignored strobe in_ready got %b exp 0", in_ready));
      expect_count(2, "R9");
      expect_call(1, 13'h71, 32'h52, 3'd0, 16'd1, "R9");

      // R10 held call
      cur_req = "R10"; got.delete();
      seg(3);
      send(hdr(1, 2, 0, 'h21));
      in_valid = 1'b1; in_data = 32'h61; out_ready = 1'b1;
      tick();
      out_ready = 1'b0; in_data = 32'h62;
      for (int k = 0; k < 4; k++) begin
         #3;
         check(out_valid === 1'b1 && in_ready === 1'b0 && out_arg === 32'h61, "R10",
               $sformatf("held got v%b r%b arg %h exp v1 r0 arg 61", out_valid, in_ready, out_arg));
         tick();
      end
      send(32'h62);
      drain();
      expect_count(2, "R10");
      expect_call(0, 13'h21, 32'h61, 3'd0, 16'd2, "R10");
      expect_call(1, 13'h22, 32'h62, 3'd0, 16'd1, "R10");

      // R11 reset in the middle of a command
      cur_req = "R11";
      seg(5);
      send(hdr(1, 5, 0, 'h10));
      send(32'h77);
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
      tick();
      check(in_ready === 1'b0 && out_valid === 1'b0, "R11",
            $sformatf("after reset got %b/%b exp 0/0", in_ready, out_valid));
      got.delete();
      send_seg('{hdr(1, 1, 2, 'h3), 32'hAA});
      drain();
      expect_count(1, "R11");
      expect_call(0, 13'h3, 32'hAA, 3'd2, 16'd1, "R11");

      // random mixed stream, random segment cuts and back-pressure
      cur_req = "R6"; got.delete();
      ws.delete();
      exp_calls = 0;
      for (int c = 0; c < 80; c++) begin
         int sel = $urandom % 7;
         int n   = $urandom % 4;
         int mt  = $urandom % 8192;
         int sb  = $urandom % 8;
         case (sel)
            0: begin ws.push_back(hdr(1, n, sb, mt)); exp_calls += n; end
            1: begin ws.push_back(hdr(3, n, sb, mt)); exp_calls += n; end
            2: begin ws.push_back(hdr(5, n, sb, mt)); exp_calls += n; end
            3: begin ws.push_back(hdr(4, $urandom % 8192, sb, mt)); exp_calls += 1; n = 0; end
            4: begin
               ws.push_back(hdr(0, 0, sb, mt));
               ws.push_back({$urandom % 65536, n[15:0]});
               exp_calls += n;
            end
            default: begin ws.push_back(hdr(2 + 4 * (sel - 5), n, sb, mt)); n = 0; end
         endcase
         for (int d = 0; d < n; d++) ws.push_back($urandom);
      end
      stall_mode = 1'b1;
      begin
         int idx = 0;
         while (idx < ws.size()) begin
            int len = $urandom % 5;
            if (idx + len > ws.size()) len = ws.size() - idx;
            seg(len);
            for (int j = 0; j < len; j++) send(ws[idx + j]);
            idx += len;
         end
      end
      stall_mode = 1'b0;
      drain();
      expect_count(exp_calls, "R6");

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule